// File: doc/BRIEF.md
# Two-Hand Card Scoring Datapath

This block keeps two hands of up to three playing cards each, one for the player and one for the banker, and reports a score from 0 to 9 for each hand. Cards come from a counter that runs on every clock cycle through the codes 1 to 13 and then starts again at 1. Because a controller elsewhere decides when to deal, and that moment is not tied to the counter, the code that gets captured behaves like a random draw from an infinite deck.

A control block outside this one raises the step strobe together with the load enable of one or more card slots. On that clock edge each enabled slot takes the counter's current code. A hand's score is the sum of its card values, modulo 10. Aces through nines count their face value. Tens, picture cards and empty slots count nothing. Everything runs on one clock, so the capture involves no clock-domain crossing.

Top module: `card_hand_dp`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every card slot of both hands is cleared to code 0 (empty), and both scores then read 0.
- R2: The card source is 1 on the first edge after reset is released. It goes up by one on every later clock edge and follows 13 with 1. A slot loaded at the edge where reset is released takes code 1, and a slot loaded 12 cycles later takes code 13.
- R3: A card slot captures the card source value only at an edge where `step` is high and its own enable bit is high. When `step` is low, or the slot's enable is low, the slot keeps its code.
- R4: Bit k of `ld_player` / `ld_banker` selects slot k, and slot k is bits [4k+3:4k] of `player_cards` / `banker_cards`. Slot 0 holds the first card. Slots load independently, and all slots enabled on the same edge receive the same code.
- R5: For scoring, codes 1 to 9 count their face value. Codes 10 to 13, 0 (empty), and the unused codes 14 and 15 count as 0.
- R6: Each score equals (value of slot 0 + value of slot 1 + value of slot 2) mod 10 on 4 bits, always in 0..9. It changes combinationally as soon as a slot changes.
- R7: When reset and loads occur on the same edge, reset wins: the slots clear even if `step` and their enables are high.
- R8: Every stored card code stays in the range 0..13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the counter and all slots |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Deal strobe; qualifies all load enables |
| ld_player | input | 3 | Per-slot load enables, player hand |
| ld_banker | input | 3 | Per-slot load enables, banker hand |
| player_cards | output | 12 | Player slot codes, slot k at [4k+3:4k] |
| banker_cards | output | 12 | Banker slot codes, slot k at [4k+3:4k] |
| player_score | output | 4 | Player hand score 0..9 |
| banker_score | output | 4 | Banker hand score 0..9 |

## Verification
The hard part is putting a chosen three-card hand into a slot set, since the only card source is a counter the ports cannot set. The bench keeps its own count of cycles since reset. It waits until that count predicts the wanted code, then pulses `step` with a single enable. This lets it walk every ordered player hand of codes 1 to 13 and a broad set of banker hands. The wrap from 13 back to 1, the choice of slot, and loads that are blocked by a low strobe or overridden by reset are driven at fixed cycle offsets from a reset release.

// File: rtl/card_hand_pkg.sv
package card_hand_pkg;

   // Default geometry of a hand and of the card code space
   localparam int unsigned DEF_CARD_W     = 4;
   localparam int unsigned DEF_CARD_MIN   = 1;
   localparam int unsigned DEF_CARD_MAX   = 13;
   localparam int unsigned DEF_FACE_MAX   = 9;
   localparam int unsigned DEF_SCORE_MOD  = 10;
   localparam int unsigned DEF_HAND_SLOTS = 3;
   localparam int unsigned NUM_HANDS      = 2;

   // Hand indices used when the hands are built by a generate loop
   typedef enum int unsigned {
      HAND_PLAYER = 0,
      HAND_BANKER = 1
   } hand_idx_e;

endpackage

// File: rtl/card_source.sv
module card_source #(
   parameter int unsigned CARD_W   = card_hand_pkg::DEF_CARD_W,
   parameter int unsigned CARD_MIN = card_hand_pkg::DEF_CARD_MIN,
   parameter int unsigned CARD_MAX = card_hand_pkg::DEF_CARD_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [CARD_W-1:0] card
);

   localparam logic [CARD_W-1:0] LO = CARD_W'(CARD_MIN);
   localparam logic [CARD_W-1:0] HI = CARD_W'(CARD_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         card <= LO;
      end else if (card == HI) begin
         card <= LO;
      end else begin
         card <= card + 1'b1;
      end
   end

endmodule

// File: rtl/card_slot.sv
module card_slot #(
   parameter int unsigned CARD_W = card_hand_pkg::DEF_CARD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [CARD_W-1:0] d,
   output logic [CARD_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (step && load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/hand_scorer.sv
module hand_scorer #(
   parameter int unsigned CARD_W     = card_hand_pkg::DEF_CARD_W,
   parameter int unsigned HAND_SLOTS = card_hand_pkg::DEF_HAND_SLOTS,
   parameter int unsigned FACE_MAX   = card_hand_pkg::DEF_FACE_MAX,
   parameter int unsigned SCORE_MOD  = card_hand_pkg::DEF_SCORE_MOD,
   parameter int unsigned SCORE_W    = $clog2(SCORE_MOD)
) (
   input  logic [HAND_SLOTS*CARD_W-1:0] cards,
   output logic [SCORE_W-1:0]           score
);

   localparam int unsigned SUM_MAX = HAND_SLOTS * FACE_MAX;
   localparam int unsigned SUM_W   = $clog2(SUM_MAX + 1);
   localparam int unsigned WRAPS   = SUM_MAX / SCORE_MOD;

   logic [HAND_SLOTS-1:0][SUM_W-1:0] pts;
   logic [SUM_W-1:0]                 sum;
   logic [SUM_W-1:0]                 rem;

   // Per-slot point value: only face codes 1..FACE_MAX count
   for (genvar i = 0; i < HAND_SLOTS; i++) begin : g_pts
      logic [CARD_W-1:0] code;
      assign code = cards[i*CARD_W +: CARD_W];
      always_comb begin
         if ((code != '0) && (code <= CARD_W'(FACE_MAX))) begin
            pts[i] = SUM_W'(code);
         end else begin
            pts[i] = '0;
         end
      end
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < HAND_SLOTS; i++) begin
         sum = sum + pts[i];
      end
   end

   // Reduction variant picked by how many times the sum can wrap
   if (WRAPS <= 3) begin : g_sub_chain
      always_comb begin
         rem = sum;
         for (int k = WRAPS; k >= 1; k--) begin
            if (rem >= SUM_W'(k * SCORE_MOD)) begin
               rem = rem - SUM_W'(k * SCORE_MOD);
            end
         end
      end
   end else begin : g_divider
      always_comb begin
         rem = sum % SUM_W'(SCORE_MOD);
      end
   end

   assign score = SCORE_W'(rem);

endmodule

// File: rtl/card_hand_dp.sv
module card_hand_dp #(
   parameter int unsigned CARD_W     = card_hand_pkg::DEF_CARD_W,
   parameter int unsigned CARD_MAX   = card_hand_pkg::DEF_CARD_MAX,
   parameter int unsigned FACE_MAX   = card_hand_pkg::DEF_FACE_MAX,
   parameter int unsigned SCORE_MOD  = card_hand_pkg::DEF_SCORE_MOD,
   parameter int unsigned HAND_SLOTS = card_hand_pkg::DEF_HAND_SLOTS,
   parameter int unsigned SCORE_W    = $clog2(SCORE_MOD)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         step,
   input  logic [HAND_SLOTS-1:0]        ld_player,
   input  logic [HAND_SLOTS-1:0]        ld_banker,
   output logic [HAND_SLOTS*CARD_W-1:0] player_cards,
   output logic [HAND_SLOTS*CARD_W-1:0] banker_cards,
   output logic [SCORE_W-1:0]           player_score,
   output logic [SCORE_W-1:0]           banker_score
);

   import card_hand_pkg::*;

   localparam int unsigned HAND_W = HAND_SLOTS * CARD_W;

   // Elaboration-time parameter checks
   if (CARD_MAX >= (1 << CARD_W)) begin : g_bad_card_w
      $error("card_hand_dp: CARD_MAX does not fit in CARD_W bits");
   end
   if (FACE_MAX > CARD_MAX) begin : g_bad_face
      $error("card_hand_dp: FACE_MAX exceeds CARD_MAX");
   end
   if (SCORE_MOD < 2 || SCORE_W < $clog2(SCORE_MOD)) begin : g_bad_mod
      $error("card_hand_dp: SCORE_MOD/SCORE_W inconsistent");
   end
   if (HAND_SLOTS < 1) begin : g_bad_slots
      $error("card_hand_dp: HAND_SLOTS must be at least 1");
   end

   logic [CARD_W-1:0]                         src_card;
   logic [NUM_HANDS-1:0][HAND_SLOTS-1:0]      ld_all;
   logic [NUM_HANDS-1:0][HAND_W-1:0]          cards_all;
   logic [NUM_HANDS-1:0][SCORE_W-1:0]         score_all;

   assign ld_all[HAND_PLAYER] = ld_player;
   assign ld_all[HAND_BANKER] = ld_banker;

   card_source #(
      .CARD_W  (CARD_W),
      .CARD_MIN(1),
      .CARD_MAX(CARD_MAX)
   ) u_src (
      .clk  (clk),
      .rst_n(rst_n),
      .card (src_card)
   );

   for (genvar h = 0; h < NUM_HANDS; h++) begin : g_hand
      for (genvar s = 0; s < HAND_SLOTS; s++) begin : g_slot
         card_slot #(
            .CARD_W(CARD_W)
         ) u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .step (step),
            .load (ld_all[h][s]),
            .d    (src_card),
            .q    (cards_all[h][s*CARD_W +: CARD_W])
         );
      end

      hand_scorer #(
         .CARD_W    (CARD_W),
         .HAND_SLOTS(HAND_SLOTS),
         .FACE_MAX  (FACE_MAX),
         .SCORE_MOD (SCORE_MOD),
         .SCORE_W   (SCORE_W)
      ) u_score (
         .cards(cards_all[h]),
         .score(score_all[h])
      );
   end

   assign player_cards = cards_all[HAND_PLAYER];
   assign banker_cards = cards_all[HAND_BANKER];
   assign player_score = score_all[HAND_PLAYER];
   assign banker_score = score_all[HAND_BANKER];

endmodule

// File: rtl/card_hand_chk.sv
module card_hand_chk #(
   parameter int unsigned CARD_W     = 4,
   parameter int unsigned CARD_MAX   = 13,
   parameter int unsigned SCORE_MOD  = 10,
   parameter int unsigned HAND_SLOTS = 3,
   parameter int unsigned SCORE_W    = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         step,
   input logic [HAND_SLOTS-1:0]        ld_player,
   input logic [HAND_SLOTS-1:0]        ld_banker,
   input logic [HAND_SLOTS*CARD_W-1:0] player_cards,
   input logic [HAND_SLOTS*CARD_W-1:0] banker_cards,
   input logic [SCORE_W-1:0]           player_score,
   input logic [SCORE_W-1:0]           banker_score,
   input logic [CARD_W-1:0]            src_card
);

   logic rst_q;

   // R1 / R7: a low reset at the previous edge leaves all slots empty
   always_ff @(posedge clk) begin
      rst_q <= rst_n;
      if (rst_q === 1'b0) begin
         p_clear_r1: assert (player_cards == '0 && banker_cards == '0)
            else $error("slots not cleared after reset");
      end
   end

   p_src_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_card >= CARD_W'(1)) && (src_card <= CARD_W'(CARD_MAX)));

   p_src_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_card == CARD_W'(CARD_MAX)) |=> (src_card == CARD_W'(1)));

   p_src_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_card != CARD_W'(CARD_MAX)) |=> (src_card == $past(src_card) + 1'b1));

   p_score_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (player_score < SCORE_W'(SCORE_MOD)) && (banker_score < SCORE_W'(SCORE_MOD)));

   for (genvar s = 0; s < HAND_SLOTS; s++) begin : g_slot_chk
      p_load_p_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (step && ld_player[s]) |=> (player_cards[s*CARD_W +: CARD_W] == $past(src_card)));
      p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (step && ld_banker[s]) |=> (banker_cards[s*CARD_W +: CARD_W] == $past(src_card)));
      p_hold_p_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(step && ld_player[s]) |=> $stable(player_cards[s*CARD_W +: CARD_W]));
      p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(step && ld_banker[s]) |=> $stable(banker_cards[s*CARD_W +: CARD_W]));
      p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (player_cards[s*CARD_W +: CARD_W] <= CARD_W'(CARD_MAX)) &&
         (banker_cards[s*CARD_W +: CARD_W] <= CARD_W'(CARD_MAX)));
   end

endmodule

bind card_hand_dp card_hand_chk #(
   .CARD_W    (CARD_W),
   .CARD_MAX  (CARD_MAX),
   .SCORE_MOD (SCORE_MOD),
   .HAND_SLOTS(HAND_SLOTS),
   .SCORE_W   (SCORE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .step        (step),
   .ld_player   (ld_player),
   .ld_banker   (ld_banker),
   .player_cards(player_cards),
   .banker_cards(banker_cards),
   .player_score(player_score),
   .banker_score(banker_score),
   .src_card    (src_card)
);

// File: tb/card_hand_dp_tb.sv
module card_hand_dp_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [2:0]  ld_player = '0;
   logic [2:0]  ld_banker = '0;
   logic [11:0] player_cards;
   logic [11:0] banker_cards;
   logic [3:0]  player_score;
   logic [3:0]  banker_score;

   int total = 0;
   int bad = 0;
   int exp_ctr;
   int exp_p[3];
   int exp_b[3];

   always #5 clk = ~clk;

   card_hand_dp u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .ld_player   (ld_player),
      .ld_banker   (ld_banker),
      .player_cards(player_cards),
      .banker_cards(banker_cards),
      .player_score(player_score),
      .banker_score(banker_score)
   );

   // Bench model of the card source count (R2)
   always @(posedge clk) begin
      if (!rst_n) exp_ctr <= 1;
      else        exp_ctr <= (exp_ctr == 13) ? 1 : exp_ctr + 1;
   end

   function automatic int pts(input int code);
      return (code >= 1 && code <= 9) ? code : 0;
   endfunction

   function automatic int hand_score(input int a, input int b, input int c);
      return (pts(a) + pts(b) + pts(c)) % 10;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_hands(input string req);
      for (int s = 0; s < 3; s++) begin
         check(req, int'(player_cards[s*4 +: 4]), exp_p[s]);
         check(req, int'(banker_cards[s*4 +: 4]), exp_b[s]);
      end
      check({req, " R6 player score"}, int'(player_score),
            hand_score(exp_p[0], exp_p[1], exp_p[2]));
      check({req, " R6 banker score"}, int'(banker_score),
            hand_score(exp_b[0], exp_b[1], exp_b[2]));
   endtask

   task automatic clear_model();
      for (int s = 0; s < 3; s++) begin
         exp_p[s] = 0;
         exp_b[s] = 0;
      end
   endtask

   // Called at a negedge; returns at the negedge after the load edge
   task automatic put_card(input bit banker, input int slot, input int code);
      while (exp_ctr != code) @(negedge clk);
      step = 1'b1;
      if (banker) ld_banker[slot] = 1'b1;
      else        ld_player[slot] = 1'b1;
      @(negedge clk);
      step = 1'b0;
      ld_player = '0;
      ld_banker = '0;
      if (banker) exp_b[slot] = code;
      else        exp_p[slot] = code;
   endtask

   task automatic pulse_reset();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      clear_model();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int pa, pb;
      clear_model();
      repeat (3) @(negedge clk);
      // R1: reset state
      check_hands("R1 reset");

      // R2: first code after release is 1, twelve cycles later 13, then 1
      rst_n = 1'b1;
      step = 1'b1;
      ld_player = 3'b001;
      @(negedge clk);
      step = 1'b0;
      ld_player = '0;
      check("R2 first code", int'(player_cards[3:0]), 1);
      repeat (11) @(negedge clk);
      step = 1'b1;
      ld_player = 3'b010;
      @(negedge clk);
      ld_player = 3'b100;
      check("R2 code 13", int'(player_cards[7:4]), 13);
      @(negedge clk);
      step = 1'b0;
      ld_player = '0;
      check("R2 wrap to 1", int'(player_cards[11:8]), 1);
      check("R5 R6 score with 13", int'(player_score), 2);
      exp_p[0] = 1; exp_p[1] = 13; exp_p[2] = 1;

      // R3: enables without strobe, strobe without enables
      ld_player = 3'b111;
      ld_banker = 3'b111;
      repeat (4) @(negedge clk);
      ld_player = '0;
      ld_banker = '0;
      check_hands("R3 no strobe hold");
      step = 1'b1;
      repeat (3) @(negedge clk);
      step = 1'b0;
      check_hands("R3 no enable hold");

      // R4: several slots on one edge receive the same code
      begin
         int code_now;
         code_now = exp_ctr;
         step = 1'b1;
         ld_player = 3'b101;
         ld_banker = 3'b010;
         @(negedge clk);
         step = 1'b0;
         ld_player = '0;
         ld_banker = '0;
         exp_p[0] = code_now; exp_p[2] = code_now; exp_b[1] = code_now;
         check_hands("R4 multi-slot load");
      end

      // R7: reset overrides load
      rst_n = 1'b0;
      step = 1'b1;
      ld_player = 3'b111;
      ld_banker = 3'b111;
      @(negedge clk);
      rst_n = 1'b1;
      step = 1'b0;
      ld_player = '0;
      ld_banker = '0;
      clear_model();
      check_hands("R7 reset beats load");

      // R5: single-card hands for every code in each slot position
      for (int c = 1; c <= 13; c++) begin
         put_card(1'b0, 0, c);
         put_card(1'b1, 2, c);
         check_hands("R5 single card");
      end
      pulse_reset();

      // R6: every ordered player hand; only changed slots are reloaded
      pa = 0; pb = 0;
      for (int a = 1; a <= 13; a++) begin
         for (int b = 1; b <= 13; b++) begin
            for (int c = 1; c <= 13; c++) begin
               if (pa != a) begin put_card(1'b0, 0, a); pa = a; end
               if (pb != b) begin put_card(1'b0, 1, b); pb = b; end
               put_card(1'b0, 2, c);
               check_hands("R6 player sweep");
            end
         end
      end

      // R6: banker hands with a derived third card
      for (int a = 1; a <= 13; a++) begin
         for (int b = 1; b <= 13; b++) begin
            put_card(1'b1, 0, a);
            put_card(1'b1, 1, b);
            put_card(1'b1, 2, ((a + b) % 13) + 1);
            check_hands("R6 banker sweep");
         end
      end

      // R1: mid-run reset clears both full hands
      pulse_reset();
      check_hands("R1 mid-run reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule